// File: doc/BRIEF.md
# Segment Loader for Instruction and Data Memory

The block takes program segments one at a time and writes them into two local memories through plain write ports. Each segment opens with a one-cycle `seg_start` strobe that carries its header: a physical address, a file size, a memory size, an offset into the image, the image size, a loadable flag and an executable flag. The payload bytes follow on a valid/ready byte stream. Executable segments go to the instruction memory. Every group of three payload bytes becomes one 32-bit word, and the top byte of that word is zero. All other segments go to the data memory one byte at a time. After the payload, the block writes zero bytes up to the segment's memory size.

The low 20 bits of the physical address are a word address. Instruction words are written at that word address plus the instruction index. Data bytes are written at four times that word address plus the byte index. A segment that ends beyond the image is rejected and consumes no bytes. When the last segment has been loaded, a `load_finish` strobe raises `run_core` to release the processor.

The control is a single state machine with six states: IDLE, INSN, PAD, DATA, FILL and RUN.
- IDLE goes to INSN on an accepted executable segment and to DATA on an accepted non-executable segment. On `load_finish` it goes to RUN.
- INSN goes to IDLE when its payload is used up on a whole word, and to PAD when a partial word is left.
- PAD always returns to IDLE.
- DATA goes to FILL when zero fill remains, and otherwise to IDLE.
- FILL returns to IDLE once the fill count reaches zero.
- RUN is left only by reset.

Top module: `seg_loader`

## Requirements
- R1: A segment with `seg_exec`=1 writes only through the instruction port. A segment with `seg_exec`=0 writes only through the data port. The two write enables are never high in the same cycle.
- R2: Instruction payload bytes b0, b1, b2, with b0 arriving first, form the word {8'h00, b2, b1, b0}.
- R3: The instruction word address is (`seg_paddr`[19:0] + word index) mod 2^20. The data byte address is `seg_paddr`[19:0]*4 + byte index.
- R4: A data segment writes its `seg_filesz` payload bytes in arrival order. It then writes `seg_memsz`-`seg_filesz` zero bytes at the following addresses. No fill is written when `seg_memsz` <= `seg_filesz`.
- R5: When an instruction segment's size is not a multiple of 3, its last word carries the remaining bytes in the low lanes and zeros in all other lanes. `part_warn` pulses for one cycle.
- R6: A `seg_start` with `seg_loadable`=0 is ignored. No write happens, `in_ready` stays low, `busy` stays low and `seg_done` does not pulse.
- R7: If `seg_offset`+`seg_filesz` > `img_size`, `seg_err` pulses for one cycle in the cycle after the strobe. No byte is consumed and nothing is written. A segment whose sum exactly equals `img_size` is loaded.
- R8: `busy` is high from the cycle after an accepted `seg_start` until the segment's last write has been issued. `in_ready` is high only while `busy` is high. `seg_done` pulses for one cycle when `busy` falls.
- R9: A `load_finish` while idle raises `run_core` in the next cycle, and `run_core` stays high until reset. While `run_core` is high, `seg_start` is ignored.
- R10: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seg_start | input | 1 | One-cycle strobe that presents a segment header |
| seg_loadable | input | 1 | Segment is of the loadable kind |
| seg_exec | input | 1 | Segment is executable |
| seg_paddr | input | 32 | Physical load address; only the low 20 bits are used |
| seg_offset | input | 16 | Offset of the segment in the image |
| seg_filesz | input | 16 | Number of payload bytes |
| seg_memsz | input | 16 | Size of the segment in memory, in bytes |
| img_size | input | 16 | Size of the whole image, in bytes |
| load_finish | input | 1 | Strobe that starts the core |
| in_valid | input | 1 | Payload byte valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block accepts a payload byte |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 20 | Instruction word address |
| imem_wdata | output | 32 | Instruction word |
| dmem_we | output | 1 | Data memory write enable |
| dmem_addr | output | 22 | Data byte address |
| dmem_wdata | output | 8 | Data byte |
| busy | output | 1 | A segment is in progress |
| seg_done | output | 1 | One-cycle pulse at the end of a segment |
| seg_err | output | 1 | One-cycle pulse when a segment is rejected |
| part_warn | output | 1 | One-cycle pulse when a partial instruction word is written |
| run_core | output | 1 | Core run enable |

## Verification
The assertions check the rules that hold on every cycle:
- the two write ports are never active together;
- back-to-back data writes step the address by one;
- each fill cycle produces a zero byte;
- `in_ready` implies `busy`, and `seg_done` is a single pulse;
- `seg_err` never appears while busy;
- `run_core` is sticky.

Other behaviour can only be shown by the bench scenarios:
- byte order inside packed words;
- wrap of the 20-bit word address;
- the padded last word and its warning;
- the exact fill length;
- the offset/size boundary;
- strobes that must leave no trace at the ports.

// File: rtl/seg_loader_pkg.sv
package seg_loader_pkg;

    localparam int INSN_BYTES = 3;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = WORD_BYTES * 8;

    typedef enum logic [2:0] {
        LS_IDLE = 3'd0,
        LS_INSN = 3'd1,
        LS_PAD  = 3'd2,
        LS_DATA = 3'd3,
        LS_FILL = 3'd4,
        LS_RUN  = 3'd5
    } ldr_state_e;

endpackage

// File: rtl/seg_insn_packer.sv
module seg_insn_packer #(
    parameter int LANES = 3,
    parameter int WB    = 4,
    localparam int CW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [7:0]        din,
    output logic [CW-1:0]     cnt,
    output logic              full,
    output logic [WB*8-1:0]   word
);

    logic [7:0] lane_q [LANES];

    // A push into the last lane completes a word.
    assign full = push && (cnt == CW'(LANES - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            for (int i = 0; i < LANES; i++) begin
                lane_q[i] <= 8'h00;
            end
        end else if (push) begin
            lane_q[cnt] <= din;
            cnt         <= (cnt == CW'(LANES - 1)) ? '0 : cnt + 1'b1;
        end
    end

    // Lanes below cnt come from storage, the lane at cnt takes the
    // incoming byte, and all higher lanes read as zero.
    for (genvar g = 0; g < WB; g++) begin : g_lane
        if (g < LANES) begin : g_used
            assign word[g*8 +: 8] = (CW'(g) < cnt) ? lane_q[g] :
                                    ((CW'(g) == cnt && push) ? din : 8'h00);
        end else begin : g_zero
            assign word[g*8 +: 8] = 8'h00;
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
    parameter int ADDR_W = 20,
    parameter int IDX_W  = 16,
    localparam int DA_W  = ADDR_W + 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] iaddr,
    output logic [DA_W-1:0]   daddr
);

    // The instruction side counts words and wraps within the address field.
    assign iaddr = base + ADDR_W'(idx);

    // The data side turns the word base into a byte address.
    assign daddr = {base, 2'b00} + DA_W'(idx);

endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import seg_loader_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int PADDR_W = 32,
    parameter int SZ_W    = 16,
    localparam int DA_W   = ADDR_W + 2,
    localparam int PK_CW  = (INSN_BYTES > 1) ? $clog2(INSN_BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_start,
    input  logic               seg_loadable,
    input  logic               seg_exec,
    input  logic [PADDR_W-1:0] seg_paddr,
    input  logic [SZ_W-1:0]    seg_offset,
    input  logic [SZ_W-1:0]    seg_filesz,
    input  logic [SZ_W-1:0]    seg_memsz,
    input  logic [SZ_W-1:0]    img_size,
    input  logic               load_finish,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               imem_we,
    output logic [ADDR_W-1:0]  imem_addr,
    output logic [WORD_W-1:0]  imem_wdata,
    output logic               dmem_we,
    output logic [DA_W-1:0]    dmem_addr,
    output logic [7:0]         dmem_wdata,
    output logic               busy,
    output logic               seg_done,
    output logic               seg_err,
    output logic               part_warn,
    output logic               run_core
);

    ldr_state_e state, nxt;

    logic [ADDR_W-1:0] base_q;
    logic [SZ_W-1:0]   rem_q;
    logic [SZ_W-1:0]   fill_q;
    logic [SZ_W-1:0]   idx_q;

    logic              too_big;
    logic              start_ok;
    logic              accept;
    logic              pk_clr;
    logic              pk_push;
    logic              pk_full;
    logic [PK_CW-1:0]  pk_cnt;
    logic [WORD_W-1:0] pk_word;
    logic [ADDR_W-1:0] ia_c;
    logic [DA_W-1:0]   da_c;
    logic              unused_paddr_hi;

    assign unused_paddr_hi = ^seg_paddr[PADDR_W-1:ADDR_W];

    // The segment must end inside the image.
    assign too_big  = ({1'b0, seg_offset} + {1'b0, seg_filesz}) > {1'b0, img_size};
    assign start_ok = (state == LS_IDLE) && seg_start && seg_loadable && !too_big;

    assign in_ready = ((state == LS_INSN) || (state == LS_DATA)) && (rem_q != '0);
    assign accept   = in_valid && in_ready;
    assign busy     = (state == LS_INSN) || (state == LS_PAD) ||
                      (state == LS_DATA) || (state == LS_FILL);
    assign run_core = (state == LS_RUN);

    assign pk_push = (state == LS_INSN) && accept;
    assign pk_clr  = start_ok || (state == LS_PAD);

    seg_insn_packer #(
        .LANES (INSN_BYTES),
        .WB    (WORD_BYTES)
    ) u_packer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pk_clr),
        .push  (pk_push),
        .din   (in_data),
        .cnt   (pk_cnt),
        .full  (pk_full),
        .word  (pk_word)
    );

    seg_addr_gen #(
        .ADDR_W (ADDR_W),
        .IDX_W  (SZ_W)
    ) u_addr (
        .base  (base_q),
        .idx   (idx_q),
        .iaddr (ia_c),
        .daddr (da_c)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= LS_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            LS_IDLE: begin
                if (start_ok) begin
                    nxt = seg_exec ? LS_INSN : LS_DATA;
                end else if (load_finish && !seg_start) begin
                    nxt = LS_RUN;
                end
            end
            LS_INSN: begin
                if (rem_q == '0) begin
                    nxt = (pk_cnt != '0) ? LS_PAD : LS_IDLE;
                end
            end
            LS_PAD: nxt = LS_IDLE;
            LS_DATA: begin
                if (rem_q == '0) begin
                    nxt = (fill_q != '0) ? LS_FILL : LS_IDLE;
                end
            end
            LS_FILL: begin
                if (fill_q == '0) begin
                    nxt = LS_IDLE;
                end
            end
            LS_RUN: nxt = LS_RUN;
            default: nxt = LS_IDLE;
        endcase
    end

    // Segment counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            rem_q  <= '0;
            fill_q <= '0;
            idx_q  <= '0;
        end else begin
            if (start_ok) begin
                base_q <= seg_paddr[ADDR_W-1:0];
                rem_q  <= seg_filesz;
                fill_q <= (seg_memsz > seg_filesz) ? (seg_memsz - seg_filesz) : '0;
                idx_q  <= '0;
            end else if ((state == LS_INSN) && accept) begin
                rem_q <= rem_q - 1'b1;
                if (pk_full) begin
                    idx_q <= idx_q + 1'b1;
                end
            end else if ((state == LS_DATA) && accept) begin
                rem_q <= rem_q - 1'b1;
                idx_q <= idx_q + 1'b1;
            end else if ((state == LS_FILL) && (fill_q != '0)) begin
                fill_q <= fill_q - 1'b1;
                idx_q  <= idx_q + 1'b1;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imem_we    <= 1'b0;
            imem_addr  <= '0;
            imem_wdata <= '0;
            dmem_we    <= 1'b0;
            dmem_addr  <= '0;
            dmem_wdata <= '0;
            seg_done   <= 1'b0;
            seg_err    <= 1'b0;
            part_warn  <= 1'b0;
        end else begin
            imem_we    <= (pk_push && pk_full) || (state == LS_PAD);
            imem_addr  <= ia_c;
            imem_wdata <= pk_word;
            dmem_we    <= ((state == LS_DATA) && accept) ||
                          ((state == LS_FILL) && (fill_q != '0));
            dmem_addr  <= da_c;
            dmem_wdata <= (state == LS_FILL) ? 8'h00 : in_data;
            seg_done   <= busy && (nxt == LS_IDLE);
            seg_err    <= (state == LS_IDLE) && seg_start && seg_loadable && too_big;
            part_warn  <= (state == LS_PAD);
        end
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        !(imem_we && dmem_we)); // R1

    AST_DADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_we && $past(dmem_we)) |-> (dmem_addr == DA_W'($past(dmem_addr) + 1'b1))); // R3

    AST_FILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == LS_FILL) && (fill_q != '0)) |=> (dmem_we && (dmem_wdata == 8'h00))); // R4

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_err |-> !busy); // R7

    AST_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seg_done |=> !seg_done); // R8

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        run_core |=> run_core); // R9

endmodule

// File: tb/tb_seg_loader.sv
`timescale 1ns/1ps
module tb_seg_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_start = 1'b0, seg_loadable = 1'b0, seg_exec = 1'b0;
    logic [31:0] seg_paddr = '0;
    logic [15:0] seg_offset = '0, seg_filesz = '0, seg_memsz = '0, img_size = '0;
    logic        load_finish = 1'b0, in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, imem_we, dmem_we, busy, seg_done, seg_err, part_warn, run_core;
    logic [19:0] imem_addr;
    logic [31:0] imem_wdata;
    logic [21:0] dmem_addr;
    logic [7:0]  dmem_wdata;

    always #2.5 clk = ~clk;

    seg_loader dut (
        .clk(clk), .rst_n(rst_n), .seg_start(seg_start), .seg_loadable(seg_loadable),
        .seg_exec(seg_exec), .seg_paddr(seg_paddr), .seg_offset(seg_offset),
        .seg_filesz(seg_filesz), .seg_memsz(seg_memsz), .img_size(img_size),
        .load_finish(load_finish), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .dmem_we(dmem_we), .dmem_addr(dmem_addr),
        .dmem_wdata(dmem_wdata), .busy(busy), .seg_done(seg_done),
        .seg_err(seg_err), .part_warn(part_warn), .run_core(run_core)
    );

    typedef struct packed { logic [19:0] a; logic [31:0] d; } iexp_t;
    typedef struct packed { logic [21:0] a; logic [7:0]  d; } dexp_t;

    iexp_t iq[$];
    dexp_t dq[$];

    int n_chk = 0, n_fail = 0;
    int done_cnt = 0, err_cnt = 0, warn_cnt = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever a write appears.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (imem_we) begin
                if (iq.size() == 0) begin
                    chk(1'b0, "R1/R6 unexpected instruction write", {12'h0, imem_addr, imem_wdata}, 64'h0);
                end else begin
                    iexp_t e;
                    e = iq.pop_front();
                    chk(imem_addr == e.a, "R3 instruction address", imem_addr, e.a);
                    chk(imem_wdata == e.d, "R2/R5 instruction word", imem_wdata, e.d);
                end
            end
            if (dmem_we) begin
                if (dq.size() == 0) begin
                    chk(1'b0, "R1/R6 unexpected data write", {34'h0, dmem_addr, dmem_wdata}, 64'h0);
                end else begin
                    dexp_t e;
                    e = dq.pop_front();
                    chk(dmem_addr == e.a, "R3 data address", dmem_addr, e.a);
                    chk(dmem_wdata == e.d, "R4 data byte", dmem_wdata, e.d);
                end
            end
            if (seg_done)  done_cnt++;
            if (seg_err)   err_cnt++;
            if (part_warn) warn_cnt++;
        end
    end

    function automatic logic [7:0] gen_byte(input int k, input int seed);
        return 8'((k * 37 + seed * 11 + 5) & 8'hFF);
    endfunction

    // Driver: pushes the expected writes, then streams the payload.
    task automatic run_seg(input bit exec, input logic [31:0] paddr, input int fsz,
                           input int msz, input int off, input int img, input int seed,
                           input bit gaps);
        int d0, w0, k, cyc, nw;
        logic [19:0] base;
        base = paddr[19:0];
        d0 = done_cnt;
        w0 = warn_cnt;
        if (exec) begin
            nw = (fsz + 2) / 3;
            for (int w = 0; w < nw; w++) begin
                iexp_t e;
                e.a = base + 20'(w);
                e.d = 32'h0;
                for (int l = 0; l < 3; l++) begin
                    if (w * 3 + l < fsz) e.d[l*8 +: 8] = gen_byte(w * 3 + l, seed);
                end
                iq.push_back(e);
            end
        end else begin
            for (int b = 0; b < ((msz > fsz) ? msz : fsz); b++) begin
                dexp_t e;
                e.a = {base, 2'b00} + 22'(b);
                e.d = (b < fsz) ? gen_byte(b, seed) : 8'h00;
                dq.push_back(e);
            end
        end
        @(negedge clk);
        seg_start = 1'b1; seg_loadable = 1'b1; seg_exec = exec; seg_paddr = paddr;
        seg_filesz = 16'(fsz); seg_memsz = 16'(msz); seg_offset = 16'(off); img_size = 16'(img);
        @(negedge clk);
        seg_start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", busy, 1);
        k = 0; cyc = 0;
        while (k < fsz) begin
            if (cyc > 0) @(negedge clk);
            cyc++;
            if (gaps && (cyc % 3 == 0)) begin
                in_valid = 1'b0;
            end else if (in_ready) begin
                in_valid = 1'b1;
                in_data  = gen_byte(k, seed);
                k++;
            end else begin
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        cyc = 0;
        while (done_cnt == d0 && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_cnt == d0 + 1, "R8 single done pulse", done_cnt - d0, 1);
        chk(busy == 1'b0, "R8 busy low after done", busy, 0);
        chk(iq.size() == 0 && dq.size() == 0, "R4 all expected writes seen",
            iq.size() + dq.size(), 0);
        if (exec) begin
            chk((warn_cnt - w0) == ((fsz % 3 != 0) ? 1 : 0), "R5 partial-word warning",
                warn_cnt - w0, (fsz % 3 != 0) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int d0, e0;
        repeat (4) @(negedge clk);
        // R10: outputs while in reset
        chk({in_ready, imem_we, dmem_we, busy, seg_done, seg_err, part_warn, run_core} == 8'h0,
            "R10 outputs low in reset",
            {in_ready, imem_we, dmem_we, busy, seg_done, seg_err, part_warn, run_core}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({in_ready, imem_we, dmem_we, busy, run_core} == 5'h0, "R10 outputs low after reset",
            {in_ready, imem_we, dmem_we, busy, run_core}, 0);

        // R1 R2 R3: two whole instructions, upper address bits masked
        run_seg(1'b1, 32'hABC0_0010, 6, 6, 0, 16'hFFFF, 1, 1'b0);
        // R5 R3: partial last word, word address wraps past 2^20
        run_seg(1'b1, 32'h000F_FFFF, 7, 7, 0, 16'hFFFF, 2, 1'b1);
        // R4: data with zero fill, throttled stream
        run_seg(1'b0, 32'h0000_0100, 5, 9, 0, 16'hFFFF, 3, 1'b1);
        // R4: memory size smaller than file size, no fill
        run_seg(1'b0, 32'h0000_0200, 4, 2, 0, 16'hFFFF, 4, 1'b0);
        // R5: empty instruction segment, no write and no warning
        run_seg(1'b1, 32'h0000_0300, 0, 0, 0, 16'hFFFF, 5, 1'b0);

        // R6: non-loadable segment ignored
        d0 = done_cnt;
        @(negedge clk);
        seg_start = 1'b1; seg_loadable = 1'b0; seg_exec = 1'b1; seg_filesz = 16'd6;
        seg_offset = '0; img_size = 16'hFFFF;
        in_valid = 1'b1; in_data = 8'h5A;
        @(negedge clk);
        seg_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            chk(busy == 1'b0 && in_ready == 1'b0, "R6 ignored segment stays idle",
                {busy, in_ready}, 0);
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(done_cnt == d0, "R6 no done pulse", done_cnt - d0, 0);

        // R7: offset + size beyond the image
        e0 = err_cnt;
        seg_start = 1'b1; seg_loadable = 1'b1; seg_exec = 1'b0;
        seg_offset = 16'd100; seg_filesz = 16'd50; seg_memsz = 16'd50; img_size = 16'd120;
        in_valid = 1'b1;
        @(negedge clk);
        seg_start = 1'b0;
        chk(seg_err == 1'b1, "R7 error pulse", seg_err, 1);
        chk(busy == 1'b0 && in_ready == 1'b0, "R7 rejected segment consumes nothing",
            {busy, in_ready}, 0);
        @(negedge clk);
        chk(seg_err == 1'b0, "R7 error is one cycle", seg_err, 0);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk(err_cnt == e0 + 1, "R7 error count", err_cnt - e0, 1);
        // R7 boundary: the sum equals the image size and is accepted
        run_seg(1'b0, 32'h0000_0040, 50, 50, 70, 120, 6, 1'b0);

        // R9: start the core, later strobes are ignored
        @(negedge clk);
        load_finish = 1'b1;
        @(negedge clk);
        load_finish = 1'b0;
        chk(run_core == 1'b1, "R9 run raised", run_core, 1);
        seg_start = 1'b1; seg_loadable = 1'b1; seg_exec = 1'b1;
        seg_offset = '0; seg_filesz = 16'd3; img_size = 16'hFFFF;
        @(negedge clk);
        seg_start = 1'b0;
        chk(busy == 1'b0 && in_ready == 1'b0, "R9 segment ignored while running",
            {busy, in_ready}, 0);
        repeat (3) @(negedge clk);
        chk(run_core == 1'b1, "R9 run stays high", run_core, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule